// File: doc/BRIEF.md
# Wide-Entry Lookup Table Register Window

This block gives a 32-bit register bus access to an on-chip lookup table whose entries are 96 bits wide. Each entry is wider than one bus word, so software builds an entry in three staging words. A single write to a control register then carries both the target row and a commit flag. When the flag is clear, the same control write fetches the addressed row back into the staging words. Software can then read the row one word at a time.

The block holds the entry storage, the three staging words and the control register. It also has two read-only registers. One gives the revision numbers. The other gives the table size and a busy flag that covers the fetch cycle. The staging words are ordered highest word first: staging word 0 carries entry bits 95..64, and staging word 2 carries bits 31..0. A forwarding engine elsewhere decodes entries in that layout. Table depth, control index width and revision numbers are parameters.

Top module: `addr_table_port`

## Requirements
- R1: A read of byte offset 0x00 returns the major revision in bits 15..8 and the minor revision in bits 7..0, with all other bits zero.
- R2: A read of offset 0x04 returns a size code in bits 4..0 and the busy flag in bit 31, with all other bits zero. The size code is 0 for a 64-row table and DEPTH/1024 for larger tables.
- R3: Writes to offsets 0x34, 0x38 and 0x3C set staging words 0, 1 and 2. Each word reads back at its own offset.
- R4: A control write (offset 0x20) with bit 31 set stores the staging words into the row given by the low index bits. Staging word 0 becomes entry bits 95..64 and staging word 2 becomes bits 31..0, so a later fetch of that row returns each word at its original offset.
- R5: A control write with bit 31 clear fetches the addressed row into the staging words on the next clock edge. For that one cycle, status bit 31 reads 1 and the staging words still read their previous values.
- R6: An index at or beyond DEPTH makes a commit store nothing, and no row is aliased. A fetch of such an index loads all zeros.
- R7: After reset every row is zero, so a fetch of any row returns zeros.
- R8: A bus write to a staging word in the same cycle that a fetch lands takes priority for that word. The other words take the fetched values.
- R9: A read of the control register returns the index field from the last control write, with bit 31 read as 0.
- R10: Read data appears one cycle after `rd_en`, qualified by `rd_valid`. Unmapped or misaligned offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data qualifier, one cycle after rd_en |

## Verification
Two functions can fall in the same cycle: a fetched row landing in the staging words, and a bus write to one of those words. The bench provokes this by issuing a fetch control write and then, on the very next cycle, writing staging word 1. It then reads all three words. The result passes only if word 1 holds the bus value and words 0 and 2 hold the stored row. A second overlap is also checked. A status read and a staging read issued in the cycle after a fetch must report busy and the pre-fetch word, and the busy flag must be gone one cycle later.

// File: rtl/atp_pkg.sv
package atp_pkg;
   localparam int WORD_W     = 32;
   localparam int WORDS      = 3;
   localparam int ENTRY_W    = WORD_W * WORDS;
   localparam int OFS_ID     = 'h00;
   localparam int OFS_STAT   = 'h04;
   localparam int OFS_CTRL   = 'h20;
   localparam int OFS_DATA   = 'h34;
   localparam int STROBE_BIT = 31;
   localparam int BUSY_BIT   = 31;
   localparam int UNIT_ROWS  = 1024;

   function automatic logic [4:0] size_code(input int depth);
      if (depth < UNIT_ROWS) return 5'd0;
      return 5'(depth / UNIT_ROWS);
   endfunction
endpackage

// File: rtl/atp_entry_store.sv
module atp_entry_store #(
   parameter int DEPTH   = 64,
   parameter int IDX_W   = 31,
   parameter int ENTRY_W = 96
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   widx,
   input  logic [ENTRY_W-1:0] wentry,
   input  logic [IDX_W-1:0]   ridx,
   output logic [ENTRY_W-1:0] rentry
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

   logic [ENTRY_W-1:0] rows [DEPTH];
   logic               w_in_range;
   logic               r_in_range;

   assign w_in_range = (widx < LIMIT);
   assign r_in_range = (ridx < LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
      end else if (we && w_in_range) begin
         rows[widx[AW-1:0]] <= wentry;
      end
   end

   assign rentry = r_in_range ? rows[ridx[AW-1:0]] : '0;
endmodule

// File: rtl/atp_stage.sv
module atp_stage #(
   parameter int WORD_W = 32,
   parameter int WORDS  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORDS-1:0]          bus_we,
   input  logic [WORD_W-1:0]         bus_wdata,
   input  logic                      load,
   input  logic [WORD_W*WORDS-1:0]   load_entry,
   output logic [WORD_W*WORDS-1:0]   stage_entry
);
   localparam int ENTRY_W = WORD_W * WORDS;

   logic [ENTRY_W-1:0] nxt;

   // word k lives in entry slice WORDS-1-k: highest bits in the lowest word
   for (genvar k = 0; k < WORDS; k++) begin : g_word
      localparam int LO = (WORDS - 1 - k) * WORD_W;
      assign nxt[LO +: WORD_W] = bus_we[k] ? bus_wdata :
                                 load      ? load_entry[LO +: WORD_W] :
                                             stage_entry[LO +: WORD_W];

      AST_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         bus_we[k] |=> stage_entry[LO +: WORD_W] == $past(bus_wdata)); // R8
      AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (load && !bus_we[k]) |=>
            stage_entry[LO +: WORD_W] == $past(load_entry[LO +: WORD_W])); // R5
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stage_entry <= '0;
      else        stage_entry <= nxt;
   end
endmodule

// File: rtl/atp_read_mux.sv
module atp_read_mux #(
   parameter int          ADDR_W    = 8,
   parameter int          IDX_W     = 31,
   parameter int          DEPTH     = 64,
   parameter logic [7:0]  VER_MAJOR = 8'h01,
   parameter logic [7:0]  VER_MINOR = 8'h04
) (
   input  logic [ADDR_W-1:0]                         addr,
   input  logic [atp_pkg::ENTRY_W-1:0]               stage_entry,
   input  logic [IDX_W-1:0]                          ctrl_idx,
   input  logic                                      busy,
   output logic [atp_pkg::WORD_W-1:0]                data
);
   import atp_pkg::*;

   logic [WORD_W-1:0] word_sel [WORDS];

   for (genvar k = 0; k < WORDS; k++) begin : g_sel
      assign word_sel[k] = stage_entry[(WORDS - 1 - k) * WORD_W +: WORD_W];
   end

   always_comb begin
      data = '0;
      if (addr == ADDR_W'(OFS_ID)) begin
         data[15:8] = VER_MAJOR;
         data[7:0]  = VER_MINOR;
      end else if (addr == ADDR_W'(OFS_STAT)) begin
         data[4:0]      = size_code(DEPTH);
         data[BUSY_BIT] = busy;
      end else if (addr == ADDR_W'(OFS_CTRL)) begin
         data[IDX_W-1:0] = ctrl_idx;
      end else begin
         for (int k = 0; k < WORDS; k++) begin
            if (addr == ADDR_W'(OFS_DATA + 4 * k)) data = word_sel[k];
         end
      end
   end
endmodule

// File: rtl/addr_table_port.sv
module addr_table_port #(
   parameter int          DEPTH      = 64,
   parameter int          ADDR_W     = 8,
   parameter int          CTRL_IDX_W = 31,
   parameter logic [7:0]  VER_MAJOR  = 8'h01,
   parameter logic [7:0]  VER_MINOR  = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              rd_valid
);
   import atp_pkg::*;

   if (!(DEPTH == 64 || (DEPTH % UNIT_ROWS == 0 && DEPTH / UNIT_ROWS <= 31))) begin : g_bad_depth
      $error("DEPTH must be 64 or a multiple of 1024 up to 31744");
   end
   if (CTRL_IDX_W <= $clog2(DEPTH) || CTRL_IDX_W > 31) begin : g_bad_idx
      $error("CTRL_IDX_W must exceed log2(DEPTH) and fit below the strobe bit");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic                    hit_ctrl;
   logic                    commit;
   logic                    load_req;
   logic [CTRL_IDX_W-1:0]   idx_in;
   logic [CTRL_IDX_W-1:0]   ctrl_idx_q;
   logic [CTRL_IDX_W-1:0]   pend_idx_q;
   logic                    pend_q;
   logic [WORDS-1:0]        data_we;
   logic [ENTRY_W-1:0]      stage_entry;
   logic [ENTRY_W-1:0]      fetched;
   logic [WORD_W-1:0]       mux_data;

   assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
   assign idx_in   = wr_data[CTRL_IDX_W-1:0];
   assign commit   = hit_ctrl &&  wr_data[STROBE_BIT];
   assign load_req = hit_ctrl && !wr_data[STROBE_BIT];

   for (genvar k = 0; k < WORDS; k++) begin : g_dec
      assign data_we[k] = wr_en && (wr_addr == ADDR_W'(OFS_DATA + 4 * k));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_idx_q <= '0;
         pend_idx_q <= '0;
         pend_q     <= 1'b0;
      end else begin
         pend_q <= load_req;
         if (hit_ctrl) ctrl_idx_q <= idx_in;
         if (load_req) pend_idx_q <= idx_in;
      end
   end

   atp_entry_store #(
      .DEPTH   (DEPTH),
      .IDX_W   (CTRL_IDX_W),
      .ENTRY_W (ENTRY_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (commit),
      .widx   (idx_in),
      .wentry (stage_entry),
      .ridx   (pend_idx_q),
      .rentry (fetched)
   );

   atp_stage #(
      .WORD_W (WORD_W),
      .WORDS  (WORDS)
   ) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (data_we),
      .bus_wdata   (wr_data),
      .load        (pend_q),
      .load_entry  (fetched),
      .stage_entry (stage_entry)
   );

   atp_read_mux #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (CTRL_IDX_W),
      .DEPTH     (DEPTH),
      .VER_MAJOR (VER_MAJOR),
      .VER_MINOR (VER_MINOR)
   ) u_mux (
      .addr        (rd_addr),
      .stage_entry (stage_entry),
      .ctrl_idx    (ctrl_idx_q),
      .busy        (pend_q),
      .data        (mux_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? mux_data : '0;
      end
   end

   AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !load_req) |=> !pend_q); // R5
   AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R10
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R10
   AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(OFS_ID)) |=>
         rd_data == {16'h0, VER_MAJOR, VER_MINOR}); // R1
   AST_SIZE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(OFS_STAT)) |=>
         rd_data[4:0] == size_code(DEPTH)); // R2
endmodule

// File: tb/sim_addr_table_port.sv
module sim_addr_table_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        rd_valid;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   localparam logic [7:0] A_ID = 8'h00, A_ST = 8'h04, A_CT = 8'h20;
   localparam logic [7:0] A_D0 = 8'h34, A_D1 = 8'h38, A_D2 = 8'h3C;
   localparam logic [31:0] COMMIT = 32'h8000_0000;

   always #4 clk = ~clk;

   addr_table_port u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // monitor: pops one expectation per returned read
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read data: got %h expected none", rd_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s: got %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic stage3(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
      bus_write(A_D0, w0);
      bus_write(A_D1, w1);
      bus_write(A_D2, w2);
   endtask

   task automatic fetch(input logic [31:0] idx);
      bus_write(A_CT, idx);
      @(negedge clk);
   endtask

   task automatic expect3(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input string t);
      bus_read(A_D0, w0, t);
      bus_read(A_D1, w1, t);
      bus_read(A_D2, w2, t);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      bus_read(A_ID, 32'h0000_0104, "R1 revision");
      bus_read(A_ST, 32'h0000_0000, "R2 size code idle");
      bus_read(A_CT, 32'h0000_0000, "R9 ctrl after reset");
      expect3(32'h0, 32'h0, 32'h0, "R3 staging after reset");

      // R7: rows cleared by reset
      stage3(32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003);
      expect3(32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003, "R3 staging readback");
      fetch(32'd7);
      expect3(32'h0, 32'h0, 32'h0, "R7 row 7 zero after reset");

      // R4: commit and round trip
      stage3(32'hA000_0000, 32'hA111_1111, 32'hA222_2222);
      bus_write(A_CT, COMMIT | 32'd5);
      bus_read(A_CT, 32'd5, "R9 ctrl index after commit");
      stage3(32'h1, 32'h2, 32'h3);
      fetch(32'd5);
      expect3(32'hA000_0000, 32'hA111_1111, 32'hA222_2222, "R4 row 5 round trip");
      stage3(32'hC0C0_0063, 32'hC1C1_0063, 32'hC2C2_0063);
      bus_write(A_CT, COMMIT | 32'd63);
      stage3(32'h0, 32'h0, 32'h0);
      fetch(32'd63);
      expect3(32'hC0C0_0063, 32'hC1C1_0063, 32'hC2C2_0063, "R4 last row");
      bus_read(A_CT, 32'd63, "R9 ctrl index 63");

      // R5: busy for one cycle, staging old during it
      stage3(32'h5555_0000, 32'h5555_0001, 32'h5555_0002);
      bus_write(A_CT, 32'd5);
      exp_q.push_back(32'h8000_0000); tag_q.push_back("R5 busy set");
      rd_en = 1'b1; rd_addr = A_ST;
      @(negedge clk);
      rd_en = 1'b0;
      bus_read(A_ST, 32'h0000_0000, "R5 busy cleared");
      expect3(32'hA000_0000, 32'hA111_1111, 32'hA222_2222, "R5 fetched row");
      bus_write(A_CT, 32'd63);
      bus_read(A_D0, 32'hA000_0000, "R5 old word during busy");
      bus_read(A_D0, 32'hC0C0_0063, "R5 new word after busy");

      // R6: out-of-range index
      stage3(32'hBAD0_0000, 32'hBAD0_0001, 32'hBAD0_0002);
      bus_write(A_CT, COMMIT | 32'd69);
      fetch(32'd5);
      expect3(32'hA000_0000, 32'hA111_1111, 32'hA222_2222, "R6 no alias onto row 5");
      fetch(32'd69);
      expect3(32'h0, 32'h0, 32'h0, "R6 out-of-range fetch zero");
      bus_read(A_CT, 32'd69, "R9 ctrl keeps index field");

      // R8: bus write collides with landing fetch
      stage3(32'hD000_0009, 32'hD111_0009, 32'hD222_0009);
      bus_write(A_CT, COMMIT | 32'd9);
      stage3(32'h0, 32'h0, 32'h0);
      bus_write(A_CT, 32'd9);
      bus_write(A_D1, 32'h7777_7777);
      expect3(32'hD000_0009, 32'h7777_7777, 32'hD222_0009, "R8 bus write wins");

      // R10: unmapped and misaligned
      bus_read(8'h10, 32'h0, "R10 unmapped reads zero");
      bus_write(8'h10, 32'hFFFF_FFFF);
      bus_write(8'h35, 32'hEEEE_EEEE);
      bus_read(8'h10, 32'h0, "R10 unmapped write ignored");
      bus_read(A_D0, 32'hD000_0009, "R10 misaligned write ignored");
      bus_read(8'h36, 32'h0, "R10 misaligned read zero");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R10 missing reads: got %0d pending expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule